// File: doc/BRIEF.md
# Frame Sync Pulse Generator

This block derives a frame-rate strobe from a high-rate clock by counting a programmable number of that clock's periods, so every frame spans an exact whole number of high-rate cycles. With a 19.44 MHz clock a ratio of 2430 yields 8 kHz, and with 77.76 MHz a ratio of 9720 does the same.

The phase of the strobe is set by two redundant 8 kHz frame references, one paired with the primary high-speed clock input and one with the secondary. A select pin names the active source. The active reference is brought into the clock domain through a two-flop synchronizer. Each rising edge on it reloads the divider, so the strobe lines up with that reference. Edges on the inactive reference do nothing. The generator runs only when a mode bit is set and a table-select pin is low. Clock synthesis and frequency qualification of the inputs are handled elsewhere.

Top module: `fs_frame_gen`

## Requirements
- R1: While `fs_mode_on` is 0 or `tbl_hi` is 1, `frame_pulse` stays 0 from the following cycle on, and the divider forgets its phase.
- R2: After the generator becomes active, no pulse appears until the first rising edge of the selected reference.
- R3: A rising edge of the selected reference first sampled high at clock edge k gives `frame_pulse` = 1 in the cycle after clock edge k+2. This is two synchronizer stages plus the output register.
- R4: Once aligned, pulses repeat every `div_ratio` cycles without any reference edge.
- R5: A selected-reference edge arriving mid-frame restarts the count, so the next pulse follows R3 timing and later ones are spaced `div_ratio` from it.
- R6: Rising edges on the unselected reference (`ref_pri` when `sec_sel` = 1, `ref_sec` when `sec_sel` = 0) leave the pulse train unchanged.
- R7: Changing `sec_sel` does not disturb the running train. Realignment happens at the next edge of the newly selected reference, and no pulse shorter or earlier than R3/R4 allow is produced.
- R8: Each pulse is exactly one clock cycle wide.
- R9: A ratio of 2430 gives consecutive pulses exactly 2430 cycles apart.
- R10: During and right after reset, `frame_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_mode_on | input | 1 | Frame sync mode bit (1 = on) |
| tbl_hi | input | 1 | Frequency-table select; must be 0 to run |
| ref_pri | input | 1 | Asynchronous 8 kHz frame reference paired with the primary clock |
| ref_sec | input | 1 | Asynchronous 8 kHz frame reference paired with the secondary clock |
| sec_sel | input | 1 | 0 = primary source active, 1 = secondary |
| div_ratio | input | 16 | High-rate cycles per frame, at least 2 |
| frame_pulse | output | 1 | One-cycle frame strobe |

## Verification
The assertions take for granted that `div_ratio` is at least 2 and stays constant while a train runs. They also assume each reference stays high for several clock cycles, so that one rising edge gives one synchronized event. The stimulus changes the ratio only while the generator is disabled. It holds every reference pulse high for three cycles and uses ratios of 20 and 2430. It places reference edges, source switches and disables well away from scheduled pulses, so that each expected pulse time follows directly from R3 to R5.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned DIV_W_DEF   = 16;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned N_REFS      = 2;
  localparam int unsigned SEL_W       = (N_REFS > 1) ? $clog2(N_REFS) : 1;
endpackage

// File: rtl/fs_ref_sync.sv
module fs_ref_sync #(
  parameter int unsigned STAGES = fs_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  // synchronized level rose since last cycle
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fs_ref_pick.sv
module fs_ref_pick #(
  parameter int unsigned NREF = fs_pkg::N_REFS,
  parameter int unsigned SW   = fs_pkg::SEL_W
) (
  input  logic [NREF-1:0] rises,
  input  logic [SW-1:0]   sel,
  output logic            hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NREF; i++)
      if (sel == SW'(i)) hit = rises[i];
  end
endmodule

// File: rtl/fs_divider.sv
module fs_divider #(
  parameter int unsigned DIV_W = fs_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hit,
  input  logic [DIV_W-1:0] ratio,
  output logic             pulse
);
  logic [DIV_W-1:0] cnt;
  logic             armed;
  logic             wrap;

  assign wrap = (cnt == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      armed <= 1'b0;
      pulse <= 1'b0;
    end else if (hit) begin
      cnt   <= '0;
      armed <= 1'b1;
      pulse <= 1'b1;
    end else if (armed && wrap) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else if (armed) begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/fs_frame_gen.sv
module fs_frame_gen #(
  parameter int unsigned DIV_W = fs_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_mode_on,
  input  logic             tbl_hi,
  input  logic             ref_pri,
  input  logic             ref_sec,
  input  logic             sec_sel,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             frame_pulse
);
  localparam int unsigned NREF = fs_pkg::N_REFS;

  logic [NREF-1:0] refs_in;
  logic [NREF-1:0] rises;
  logic            run;
  logic            ref_hit;

  assign refs_in = {ref_sec, ref_pri};
  assign run     = fs_mode_on & ~tbl_hi;

  for (genvar g = 0; g < NREF; g++) begin : g_sync
    fs_ref_sync #(.STAGES(fs_pkg::SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (refs_in[g]),
      .rise (rises[g])
    );
  end

  fs_ref_pick #(.NREF(NREF), .SW(fs_pkg::SEL_W)) u_pick (
    .rises(rises),
    .sel  (fs_pkg::SEL_W'(sec_sel)),
    .hit  (ref_hit)
  );

  fs_divider #(.DIV_W(DIV_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .hit  (ref_hit),
    .ratio(div_ratio),
    .pulse(frame_pulse)
  );
endmodule

// File: rtl/fs_frame_gen_chk.sv
module fs_frame_gen_chk #(
  parameter int unsigned DIV_W = fs_pkg::DIV_W_DEF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             ref_hit,
  input logic [DIV_W-1:0] div_ratio,
  input logic             frame_pulse
);
  logic [DIV_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n || frame_pulse) gap <= '0;
    else if (gap != '1)        gap <= gap + 1'b1;
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !frame_pulse); // R1

  AST_EDGE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ref_hit) |=> frame_pulse); // R3

  AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && $past(run) && $stable(div_ratio) && !$past(ref_hit) && $past(rst_n))
      |-> (gap == div_ratio - 1'b1)); // R4

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_pulse && div_ratio >= 2) |=> !frame_pulse); // R8

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !frame_pulse); // R10
endmodule

bind fs_frame_gen fs_frame_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .ref_hit    (ref_hit),
  .div_ratio  (div_ratio),
  .frame_pulse(frame_pulse)
);

// File: tb/tb_fs_frame_gen.sv
module tb_fs_frame_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_mode_on = 1'b0;
  logic        tbl_hi = 1'b0;
  logic        ref_pri = 1'b0;
  logic        ref_sec = 1'b0;
  logic        sec_sel = 1'b0;
  logic [15:0] div_ratio = 16'd20;
  logic        frame_pulse;

  typedef struct { int at; string tag; } exp_t;
  exp_t  q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  string idle_tag = "R10";
  bit    prev_pulse = 1'b0;
  bit    done = 1'b0;

  fs_frame_gen dut (
    .clk(clk), .rst_n(rst_n), .fs_mode_on(fs_mode_on), .tbl_hi(tbl_hi),
    .ref_pri(ref_pri), .ref_sec(ref_sec), .sec_sel(sec_sel),
    .div_ratio(div_ratio), .frame_pulse(frame_pulse)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares observed pulses against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s: missed pulse, actual none, expected at cycle %0d", q[0].tag, q[0].at);
        void'(q.pop_front());
      end
      if (prev_pulse) begin
        n_cmp++;
        if (frame_pulse) begin
          n_bad++;
          $display("FAIL R8: pulse width, actual >1 cycle, expected 1 (cycle %0d)", cyc);
        end
      end
      if (frame_pulse && !prev_pulse) begin
        n_cmp++;
        if (q.size() > 0 && q[0].at == cyc) void'(q.pop_front());
        else begin
          n_bad++;
          $display("FAIL %s: unexpected pulse, actual cycle %0d, expected %0d", idle_tag, cyc,
                   (q.size() > 0) ? q[0].at : -1);
        end
      end
      prev_pulse = frame_pulse;
    end
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push_train(input int first, input int k0, input int k1, input int rat, input string tag);
    for (int k = k0; k < k1; k++) q.push_back('{first + k*rat, tag});
  endtask

  // drive a reference edge at a negedge; scheduled pulses are pushed by caller
  task automatic fire(input bit sec, output int c);
    @(negedge clk);
    c = cyc;
    if (sec) ref_sec = 1'b1; else ref_pri = 1'b1;
  endtask

  task automatic release_refs();
    repeat (3) @(negedge clk);
    ref_pri = 1'b0; ref_sec = 1'b0;
  endtask

  initial begin
    int c0, c1, c2, c3, c4;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (frame_pulse !== 1'b0) begin
      n_bad++; $display("FAIL R10: in reset actual %b expected 0", frame_pulse);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (frame_pulse !== 1'b0) begin
      n_bad++; $display("FAIL R10: after reset actual %b expected 0", frame_pulse);
    end

    // R2: enabled but unaligned, no pulses; R6: secondary edge while primary selected
    idle_tag = "R2";
    fs_mode_on = 1'b1; tbl_hi = 1'b0; sec_sel = 1'b0; div_ratio = 16'd20;
    repeat (30) @(negedge clk);
    idle_tag = "R6";
    fire(1'b1, c0); release_refs();
    repeat (30) @(negedge clk);

    // R3/R4: primary edge aligns, free run
    idle_tag = "R4";
    fire(1'b0, c0); push_train(c0 + 3, 0, 5, 20, "R3/R4");
    release_refs();
    wait_to(c0 + 90);
    // R5: mid-frame realign
    idle_tag = "R5";
    fire(1'b0, c1); push_train(c1 + 3, 0, 3, 20, "R5");
    release_refs();
    wait_to(c1 + 45);
    // R6: unselected reference ignored
    idle_tag = "R6";
    begin int cx; fire(1'b1, cx); end
    push_train(c1 + 3, 3, 5, 20, "R6");
    release_refs();
    wait_to(c1 + 90);
    // R7: switch to secondary, train continues, realign on secondary edge
    idle_tag = "R7";
    sec_sel = 1'b1;
    push_train(c1 + 3, 5, 7, 20, "R7");
    wait_to(c1 + 130);
    fire(1'b1, c2); push_train(c2 + 3, 0, 3, 20, "R7");
    release_refs();
    wait_to(c2 + 10);
    begin int cx; fire(1'b0, cx); end   // old primary now ignored
    release_refs();
    wait_to(c2 + 50);

    // R1: table select high silences; R2: re-enable waits for an edge
    idle_tag = "R1";
    tbl_hi = 1'b1;
    wait_to(c2 + 110);
    idle_tag = "R2";
    tbl_hi = 1'b0;
    wait_to(c2 + 140);
    fire(1'b1, c3); push_train(c3 + 3, 0, 2, 20, "R2/R3");
    release_refs();
    wait_to(c3 + 30);
    idle_tag = "R1";
    fs_mode_on = 1'b0;
    wait_to(c3 + 70);

    // R9: 19.44 MHz ratio
    div_ratio = 16'd2430;
    fs_mode_on = 1'b1;
    idle_tag = "R9";
    repeat (5) @(negedge clk);
    fire(1'b1, c4); push_train(c4 + 3, 0, 3, 2430, "R9");
    release_refs();
    wait_to(c4 + 4870);
    idle_tag = "R1";
    tbl_hi = 1'b1;
    repeat (10) @(negedge clk);

    n_cmp++;
    if (q.size() != 0) begin
      n_bad++; $display("FAIL R4: leftover expected pulses, actual %0d, expected 0", q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule